// File: doc/BRIEF.md
# Password-Gated Register Map Controller

This block is the register layer behind a byte-oriented two-wire slave front end. The front end reports bus events as one-cycle strobes: start, repeated start, stop, the slave address byte with its direction bit, each data byte sent by the master, and each byte the master reads. From these strobes the block keeps a register pointer, collects incoming data into a one-row buffer, and returns the byte at the pointer for reads.

Buffered writes reach the register storage only when the transaction closes with a stop. A repeated start throws the buffer away. A 32-bit entry key is compared with a 32-bit stored key, and the counters, limits, configuration, stored key and user area can only be changed while the two match. Both keys start as all ones, so the block comes out of reset unlocked.

A commit that touches nonvolatile locations starts a busy window of `BUSY_CYCLES` clocks. During that window the front end must not acknowledge the slave address, and the block ignores it. While the filtered event level is high, writes are dropped and reads still work.

Top module: `pw_regmap_ctrl`

## Requirements
- R1: Reads return 00h at 00h, `status_in` at 01h, 00h anywhere in 02h–05h and 1Ah–1Dh, the stored byte at 08h–0Dh, 10h–16h and 20h–2Fh, and FFh at every other address (06h–07h, 0Eh–0Fh, 17h–19h, 1Eh–1Fh, 30h–FFh).
- R2: After reset `busy` and `clr_alarm` are 0, every stored byte reads 00h, both keys are FFFFFFFFh, and the block is unlocked.
- R3: In a write, the first data byte sets the pointer. Each later byte goes to the pointer, and the pointer then steps by one inside its aligned 8-byte row, wrapping from offset 7 to offset 0. Three bytes written from 2Eh land at 2Eh, 2Fh and 28h.
- R4: Each byte read advances the pointer by one across the full 8-bit range. A read with no preceding address byte starts at the pointer left by the previous access.
- R5: Buffered bytes take effect only at a stop. A repeated start discards them, starts no busy window, and leaves the registers unchanged.
- R6: When the entry key differs from the stored key, writes to 08h–0Dh, 10h–16h, 1Ah–1Dh and 20h–2Fh are dropped. All of these locations stay readable.
- R7: Both keys are little-endian: the lowest address holds bits 7:0. A key is updated only when all four of its bytes are written in one transaction. A partial key write leaves both keys unchanged.
- R8: A new stored key takes effect at the stop of its transaction. From the next transaction on, it governs access.
- R9: While `evt_level` is high, data bytes and commits are ignored and no busy window starts. Setting the pointer and reading still work.
- R10: A stop that commits at least one nonvolatile byte (08h–0Dh, 10h–16h, 1Ah–1Dh, 20h–2Fh) holds `busy` high for exactly `BUSY_CYCLES` cycles. While `busy` is high the slave address is ignored, so the rest of that transaction has no effect. Commits that touch only 00h–05h start no busy window.
- R11: Committing a byte with bit 0 set to address 00h pulses `clr_alarm` for one cycle, in the cycle after the stop. Bit 0 clear gives no pulse.
- R12: `cfg_q` always shows the stored byte at 16h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_level | input | 1 | Filtered event level; high blocks writes |
| ev_start | input | 1 | Start condition strobe |
| ev_rstart | input | 1 | Repeated start strobe |
| ev_stop | input | 1 | Stop condition strobe |
| ev_devaddr | input | 1 | Slave address byte received |
| dev_rd | input | 1 | Direction bit of the slave address byte, 1 = read |
| ev_wbyte | input | 1 | Data byte received from the master |
| ev_rbyte | input | 1 | Byte at `rd_byte` taken by the master |
| bus_byte | input | 8 | Received byte value |
| status_in | input | 8 | Value returned at 01h |
| rd_byte | output | 8 | Byte at the current pointer |
| busy | output | 1 | Write-busy window; front end must not acknowledge |
| clr_alarm | output | 1 | One-cycle alarm-clear pulse |
| cfg_q | output | 8 | Stored configuration byte |

## Verification
The assertions assume that at most one bus strobe is active in any cycle and that `evt_level` is already synchronous and filtered. They also assume that the front end raises no data strobes of its own accord during the busy window. This matters because the countdown property holds only if nothing can reach a commit while `busy` is high. The stimulus drives exactly one strobe per cycle, changes `evt_level` only between transactions, and always waits for `busy` to fall before the next access, except in the single scenario that tries to address the block inside the window.

// File: rtl/pw_regmap_ctrl.sv
module pw_regmap_ctrl #(
  parameter int BUSY_CYCLES = 64
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       evt_level,
  input  logic       ev_start,
  input  logic       ev_rstart,
  input  logic       ev_stop,
  input  logic       ev_devaddr,
  input  logic       dev_rd,
  input  logic       ev_wbyte,
  input  logic       ev_rbyte,
  input  logic [7:0] bus_byte,
  input  logic [7:0] status_in,
  output logic [7:0] rd_byte,
  output logic       busy,
  output logic       clr_alarm,
  output logic [7:0] cfg_q
);
  localparam int BW = $clog2(BUSY_CYCLES + 1);
  localparam int MLO = 8;
  localparam int MHI = 47;
  localparam logic [7:0] CFG_ADDR = 8'h16;

  function automatic logic is_prot(input logic [7:0] a);
    return (a >= 8'h08 && a <= 8'h0D) || (a >= 8'h10 && a <= 8'h16) ||
           (a >= 8'h20 && a <= 8'h2F);
  endfunction

  logic [7:0]    ptr;
  logic [4:0]    row;
  logic          wr_active, need_ptr;
  logic [7:0]    bmask;
  logic [7:0]    bdat [8];
  logic [31:0]   pwe_q, pwv_q;
  logic [BW-1:0] busy_cnt;
  logic [7:0]    mem [MLO:MHI];
  logic [MHI:MLO] wen;

  assign busy  = (busy_cnt != '0);
  assign cfg_q = mem[CFG_ADDR[5:0]];

  wire unlocked = (pwe_q == pwv_q);
  wire commit   = ev_stop && wr_active && !evt_level;
  wire pwe_full = (row == 5'd0) && (&bmask[5:2]);
  wire pwv_full = (row == 5'd3) && (&bmask[5:2]);
  wire pwe_wr   = commit && pwe_full;
  wire pwv_wr   = commit && unlocked && pwv_full;
  wire clr_hit  = commit && (row == 5'd0) && bmask[0] && bdat[0][0];

  always_comb begin
    for (int j = MLO; j <= MHI; j++) begin
      wen[j] = commit && unlocked && is_prot(8'(j)) && (row == 5'(j >> 3)) && bmask[j % 8];
    end
  end

  wire nv_hit = (|wen) || pwv_wr;

  always_comb begin
    if (ptr == 8'h01) rd_byte = status_in;
    else if (ptr == 8'h00 || (ptr >= 8'h02 && ptr <= 8'h05) ||
             (ptr >= 8'h1A && ptr <= 8'h1D)) rd_byte = 8'h00;
    else if (is_prot(ptr)) rd_byte = mem[ptr[5:0]];
    else rd_byte = 8'hFF;
  end

  always_ff @(posedge clk) begin
    if (ev_wbyte && wr_active && !need_ptr && !evt_level) bdat[ptr[2:0]] <= bus_byte;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr       <= '0;
      row       <= '0;
      wr_active <= 1'b0;
      need_ptr  <= 1'b0;
      bmask     <= '0;
      pwe_q     <= '1;
      pwv_q     <= '1;
      busy_cnt  <= '0;
      clr_alarm <= 1'b0;
      for (int j = MLO; j <= MHI; j++) mem[j] <= '0;
    end else begin
      clr_alarm <= clr_hit;
      if (nv_hit) busy_cnt <= BW'(BUSY_CYCLES);
      else if (busy) busy_cnt <= busy_cnt - 1'b1;
      if (pwe_wr) pwe_q <= {bdat[5], bdat[4], bdat[3], bdat[2]};
      if (pwv_wr) pwv_q <= {bdat[5], bdat[4], bdat[3], bdat[2]};
      for (int j = MLO; j <= MHI; j++) begin
        if (wen[j]) mem[j] <= bdat[j % 8];
      end
      if (ev_start || ev_rstart || ev_stop) begin
        wr_active <= 1'b0;
        bmask     <= '0;
      end else if (ev_devaddr && !busy) begin
        wr_active <= !dev_rd;
        need_ptr  <= !dev_rd;
        bmask     <= '0;
      end else if (ev_wbyte && wr_active) begin
        if (need_ptr) begin
          ptr      <= bus_byte;
          row      <= bus_byte[7:3];
          need_ptr <= 1'b0;
        end else begin
          if (!evt_level) bmask[ptr[2:0]] <= 1'b1;
          ptr <= {ptr[7:3], ptr[2:0] + 3'd1};
        end
      end else if (ev_rbyte) begin
        ptr <= ptr + 8'd1;
      end
    end
  end

  a_r6_locked_cfg_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (pwe_q != pwv_q) |=> $stable(cfg_q));
  a_r9_evt_blocks_cfg: assert property (@(posedge clk) disable iff (!rst_n)
    evt_level |=> $stable(cfg_q));
  a_r9_evt_no_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_stop && evt_level && !busy) |=> !busy);
  a_r5_rstart_no_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_rstart && !busy) |=> !busy);
  a_r10_countdown: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (busy_cnt == $past(busy_cnt) - 1'b1));
  a_r11_clr_after_stop: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(clr_alarm) |-> $past(ev_stop));
  a_r8_key_at_stop: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(pwv_q) |-> $past(ev_stop));
endmodule

// File: tb/tb_pw_regmap_ctrl.sv
module tb_pw_regmap_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int BUSY = 20;
  localparam int K_START = 0, K_RSTART = 1, K_STOP = 2, K_DEV = 3, K_WB = 4, K_RB = 5;

  logic clk = 0, rst_n = 0, evt_level = 0;
  logic ev_start = 0, ev_rstart = 0, ev_stop = 0, ev_devaddr = 0, dev_rd = 0;
  logic ev_wbyte = 0, ev_rbyte = 0;
  logic [7:0] bus_byte = 0, status_in = 8'h5A;
  logic [7:0] rd_byte, cfg_q;
  logic busy, clr_alarm;
  int errors = 0, checks = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pw_regmap_ctrl #(.BUSY_CYCLES(BUSY)) dut (
    .clk(clk), .rst_n(rst_n), .evt_level(evt_level), .ev_start(ev_start),
    .ev_rstart(ev_rstart), .ev_stop(ev_stop), .ev_devaddr(ev_devaddr), .dev_rd(dev_rd),
    .ev_wbyte(ev_wbyte), .ev_rbyte(ev_rbyte), .bus_byte(bus_byte), .status_in(status_in),
    .rd_byte(rd_byte), .busy(busy), .clr_alarm(clr_alarm), .cfg_q(cfg_q));

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic strobe(input int kind, input logic [7:0] b, input logic rd);
    bus_byte = b; dev_rd = rd;
    case (kind)
      K_START:  ev_start = 1;
      K_RSTART: ev_rstart = 1;
      K_STOP:   ev_stop = 1;
      K_DEV:    ev_devaddr = 1;
      K_WB:     ev_wbyte = 1;
      default:  ev_rbyte = 1;
    endcase
    @(negedge clk);
    {ev_start, ev_rstart, ev_stop, ev_devaddr, ev_wbyte, ev_rbyte} = '0;
  endtask

  task automatic wr_txn(input logic [7:0] a, input int n, input logic [7:0] d [4], input bit use_stop);
    strobe(K_START, 0, 0);
    strobe(K_DEV, 0, 0);
    strobe(K_WB, a, 0);
    for (int i = 0; i < n; i++) strobe(K_WB, d[i], 0);
    strobe(use_stop ? K_STOP : K_RSTART, 0, 0);
  endtask

  task automatic settle();
    for (int i = 0; i < 1000 && busy; i++) @(negedge clk);
  endtask

  task automatic rd1(input logic [7:0] a, output logic [7:0] v);
    strobe(K_START, 0, 0);
    strobe(K_DEV, 0, 0);
    strobe(K_WB, a, 0);
    strobe(K_RSTART, 0, 0);
    strobe(K_DEV, 0, 1);
    v = rd_byte;
    strobe(K_RB, 0, 0);
    strobe(K_STOP, 0, 0);
  endtask

  task automatic t_reset();
    logic [7:0] v;
    check("R2 busy", busy, 0);
    check("R2 clr_alarm", clr_alarm, 0);
    check("R12 cfg_q reset", cfg_q, 0);
    rd1(8'h20, v); check("R2 user byte", v, 8'h00);
    rd1(8'h0A, v); check("R2 time counter", v, 8'h00);
  endtask

  task automatic t_map();
    logic [7:0] v;
    rd1(8'h01, v); check("R1 status", v, 8'h5A);
    rd1(8'h02, v); check("R1 entry key reads zero", v, 8'h00);
    rd1(8'h1B, v); check("R1 stored key reads zero", v, 8'h00);
    rd1(8'h07, v); check("R1 reserved 07h", v, 8'hFF);
    rd1(8'h0E, v); check("R1 reserved 0Eh", v, 8'hFF);
    rd1(8'h40, v); check("R1 nonexistent 40h", v, 8'hFF);
  endtask

  task automatic t_cfg_busy();
    logic [7:0] v;
    int cnt = 0;
    wr_txn(8'h16, 1, '{8'h03, 0, 0, 0}, 1);
    check("R10 busy after commit", busy, 1);
    while (busy && cnt < 1000) begin @(negedge clk); cnt++; end
    check("R10 busy length", cnt, BUSY);
    check("R12 cfg_q", cfg_q, 8'h03);
    rd1(8'h16, v); check("R12 cfg read", v, 8'h03);
  endtask

  task automatic t_wrap();
    logic [7:0] v;
    wr_txn(8'h2E, 3, '{8'hA1, 8'hA2, 8'hA3, 0}, 1); settle();
    rd1(8'h2E, v); check("R3 2Eh", v, 8'hA1);
    rd1(8'h2F, v); check("R3 2Fh", v, 8'hA2);
    rd1(8'h28, v); check("R3 wrapped 28h", v, 8'hA3);
    rd1(8'h29, v); check("R3 29h untouched", v, 8'h00);
  endtask

  task automatic t_read_seq();
    logic [7:0] v;
    strobe(K_START, 0, 0); strobe(K_DEV, 0, 0); strobe(K_WB, 8'h2F, 0);
    strobe(K_RSTART, 0, 0); strobe(K_DEV, 0, 1);
    check("R4 first byte", rd_byte, 8'hA2);
    strobe(K_RB, 0, 0);
    check("R4 crosses to 30h", rd_byte, 8'hFF);
    strobe(K_STOP, 0, 0);
    rd1(8'h2E, v); check("R4 single read", v, 8'hA1);
    strobe(K_START, 0, 0); strobe(K_DEV, 0, 1);
    check("R4 read continues at pointer", rd_byte, 8'hA2);
    strobe(K_RB, 0, 0); strobe(K_STOP, 0, 0);
  endtask

  task automatic t_rstart();
    logic [7:0] v;
    wr_txn(8'h21, 1, '{8'h77, 0, 0, 0}, 0);
    check("R5 no busy after repeated start", busy, 0);
    strobe(K_STOP, 0, 0);
    check("R5 no busy after later stop", busy, 0);
    rd1(8'h21, v); check("R5 discarded", v, 8'h00);
  endtask

  task automatic t_clr();
    wr_txn(8'h00, 1, '{8'h01, 0, 0, 0}, 1);
    check("R11 pulse", clr_alarm, 1);
    check("R10 volatile no busy", busy, 0);
    @(negedge clk);
    check("R11 pulse one cycle", clr_alarm, 0);
    wr_txn(8'h00, 1, '{8'h00, 0, 0, 0}, 1);
    check("R11 no pulse for bit0 clear", clr_alarm, 0);
  endtask

  task automatic t_evt();
    logic [7:0] v;
    evt_level = 1;
    wr_txn(8'h16, 1, '{8'h00, 0, 0, 0}, 1);
    check("R9 no busy", busy, 0);
    check("R9 cfg kept", cfg_q, 8'h03);
    rd1(8'h16, v); check("R9 read works", v, 8'h03);
    evt_level = 0;
    @(negedge clk);
  endtask

  task automatic t_keys();
    logic [7:0] v;
    wr_txn(8'h1A, 3, '{8'h11, 8'h22, 8'h33, 0}, 1);
    check("R7 partial stored key no busy", busy, 0);
    wr_txn(8'h16, 1, '{8'h01, 0, 0, 0}, 1); settle();
    check("R7 still unlocked", cfg_q, 8'h01);
    wr_txn(8'h1A, 4, '{8'h78, 8'h56, 8'h34, 8'h12}, 1);
    check("R8 key commit busy", busy, 1);
    strobe(K_START, 0, 0); strobe(K_DEV, 0, 0); strobe(K_WB, 8'h28, 0);
    strobe(K_WB, 8'h55, 0); strobe(K_STOP, 0, 0);
    settle();
    rd1(8'h28, v); check("R10 address ignored while busy", v, 8'hA3);
    wr_txn(8'h16, 1, '{8'h02, 0, 0, 0}, 1);
    check("R8 locked no busy", busy, 0);
    check("R6 cfg locked", cfg_q, 8'h01);
    wr_txn(8'h24, 1, '{8'h99, 0, 0, 0}, 1);
    rd1(8'h24, v); check("R6 user write dropped", v, 8'h00);
    rd1(8'h2E, v); check("R6 user readable locked", v, 8'hA1);
    wr_txn(8'h02, 3, '{8'h78, 8'h56, 8'h34, 0}, 1);
    wr_txn(8'h16, 1, '{8'h02, 0, 0, 0}, 1);
    check("R7 partial entry no unlock", cfg_q, 8'h01);
    wr_txn(8'h02, 4, '{8'h12, 8'h34, 8'h56, 8'h78}, 1);
    wr_txn(8'h16, 1, '{8'h02, 0, 0, 0}, 1);
    check("R7 wrong byte order no unlock", cfg_q, 8'h01);
    wr_txn(8'h02, 4, '{8'h78, 8'h56, 8'h34, 8'h12}, 1);
    check("R10 entry key no busy", busy, 0);
    wr_txn(8'h16, 1, '{8'h02, 0, 0, 0}, 1);
    check("R6 unlocked write busy", busy, 1);
    settle();
    check("R6 unlocked cfg", cfg_q, 8'h02);
    rd1(8'h05, v); check("R1 entry key still zero", v, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_map();
    t_cfg_busy();
    t_wrap();
    t_read_seq();
    t_rstart();
    t_clr();
    t_evt();
    t_keys();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule